// File: doc/BRIEF.md
# Conversion Result Handoff with Active-Low Ready Flag

This block sits between a converter's result path and its serial host port. A finished conversion result is offered on a strobe together with its word. The block puts the word into a staging register and opens a guard window. During the window the active-low ready flag is high, and the old word stays visible on the output register. When the window closes, the staged word moves into the output register and the ready flag falls. This tells the host that a fresh, unread word is waiting.

The serial side gives a read-complete strobe when it has finished shifting the word out. That strobe drives the flag high again. The converter can also hold the flag high for as long as it keeps its update-pending level asserted. The flag level is copied into one bit of a status byte. The other bits of that byte are passed through from the register that owns them.

Top module: `drdy_flag_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `drdy_n` is 1, `out_word` is 0 and bit 7 of `stat_reg` is 1.
- R2: A cycle with `res_stb` high makes `drdy_n` high from the next cycle on. It then stays high for exactly `PRE_CYC` cycles (default 4), and after that it goes low with `out_word` equal to the strobed word.
- R3: `out_word` keeps its previous value during the whole guard window. A read made during the window sees the old word.
- R4: When `drdy_n` is low, a cycle with `rd_done` high makes `drdy_n` high in the next cycle, and `out_word` is unchanged.
- R5: `rd_done` is ignored while the guard window is open. The pending word is still loaded, and `drdy_n` goes low when the window ends.
- R6: A new `res_stb` during an open window replaces the staged word and restarts the window at its full length. Only the newest word reaches `out_word`.
- R7: `drdy_n` is high in every cycle in which `upd_pending` is high. When `upd_pending` drops, the flag returns to the level that the word state gives, so an unread word still shows as ready.
- R8: Bit 7 of `stat_reg` always equals `drdy_n`. Bits 6..0 of `stat_reg` equal `cfg_bits[6:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| res_stb | input | 1 | new conversion result strobe |
| res_word | input | 24 | result word, valid with `res_stb` |
| upd_pending | input | 1 | converter level that forces the ready flag high |
| rd_done | input | 1 | read-complete strobe from the serial interface |
| cfg_bits | input | 7 | other fields of the status byte |
| drdy_n | output | 1 | active-low data-ready flag |
| out_word | output | 24 | output data register |
| stat_reg | output | 8 | status byte, bit 7 mirrors `drdy_n` |

## Verification
The bench goes after the following corner cases:
- **Window length.** It measures the length of the high window cycle by cycle. An off-by-one counter would show four high cycles as three or five.
- **Read during the window.** It issues reads inside the window. A design that honoured such a read would drop the pending word, and the flag would never fall.
- **Back-to-back strobes.** It sends a second strobe before the window expires. A design that did not restart would load the older word, or load too early.
- **Update-pending over an unread word.** It holds update-pending high while a word is still unread. A design that cleared the word state there would lose the ready indication once the level dropped.

Random traffic mixes all four inputs against a cycle model.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
   // status byte geometry
   localparam int unsigned STAT_W   = 8;
   localparam int unsigned STAT_BIT = 7;

   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/drdy_win_timer.sv
module drdy_win_timer #(
   parameter int unsigned PRE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic fire
);
   import drdy_pkg::*;
   localparam int unsigned CW = cnt_bits(PRE_CYC);
   localparam logic [CW-1:0] LOAD = CW'(PRE_CYC);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt_q;

   assign busy = (cnt_q != '0);
   // final cycle of the window, unless a newer strobe restarts it
   assign fire = (cnt_q == ONE) && !start;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= LOAD;
      else if (busy)
         cnt_q <= cnt_q - ONE;
   end
endmodule

// File: rtl/drdy_word_reg.sv
module drdy_word_reg #(
   parameter int unsigned W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] cap_word,
   input  logic         load,
   input  logic         busy,
   input  logic         rd_done,
   output logic [W-1:0] out_word,
   output logic         fresh
);
   logic [W-1:0] stage_q;
   logic [W-1:0] out_q;
   logic         fresh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
         out_q   <= '0;
         fresh_q <= 1'b0;
      end else begin
         if (cap)
            stage_q <= cap_word;
         if (load) begin
            out_q   <= stage_q;
            fresh_q <= 1'b1;
         end else if (rd_done && !busy) begin
            fresh_q <= 1'b0;
         end
      end
   end

   assign out_word = out_q;
   assign fresh    = fresh_q;
endmodule

// File: rtl/drdy_stat_merge.sv
module drdy_stat_merge #(
   parameter int unsigned SW  = 8,
   parameter int unsigned POS = 7
) (
   input  logic          flag,
   input  logic [SW-2:0] others,
   output logic [SW-1:0] stat
);
   for (genvar i = 0; i < SW; i++) begin : g_bit
      if (i == POS) begin : g_flag
         assign stat[i] = flag;
      end else if (i < POS) begin : g_lo
         assign stat[i] = others[i];
      end else begin : g_hi
         assign stat[i] = others[i-1];
      end
   end
endmodule

// File: rtl/drdy_flag_gen.sv
module drdy_flag_gen #(
   parameter int unsigned W       = 24,
   parameter int unsigned PRE_CYC = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         res_stb,
   input  logic [W-1:0]                 res_word,
   input  logic                         upd_pending,
   input  logic                         rd_done,
   input  logic [drdy_pkg::STAT_W-2:0]  cfg_bits,
   output logic                         drdy_n,
   output logic [W-1:0]                 out_word,
   output logic [drdy_pkg::STAT_W-1:0]  stat_reg
);
   import drdy_pkg::*;

   if (PRE_CYC < 1) begin : g_bad_pre
      $error("drdy_flag_gen: PRE_CYC must be at least 1");
   end
   if (W < 1) begin : g_bad_w
      $error("drdy_flag_gen: W must be at least 1");
   end
   if (STAT_BIT >= STAT_W) begin : g_bad_pos
      $error("drdy_flag_gen: status bit outside the status byte");
   end

   logic win_busy;
   logic win_fire;
   logic word_fresh;

   drdy_win_timer #(.PRE_CYC(PRE_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (res_stb),
      .busy  (win_busy),
      .fire  (win_fire)
   );

   drdy_word_reg #(.W(W)) u_words (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (res_stb),
      .cap_word (res_word),
      .load     (win_fire),
      .busy     (win_busy),
      .rd_done  (rd_done),
      .out_word (out_word),
      .fresh    (word_fresh)
   );

   // high when nothing unread, when the guard window is open, or when held off
   assign drdy_n = !word_fresh || win_busy || upd_pending;

   drdy_stat_merge #(.SW(STAT_W), .POS(STAT_BIT)) u_stat (
      .flag   (drdy_n),
      .others (cfg_bits),
      .stat   (stat_reg)
   );
endmodule

// File: rtl/drdy_flag_gen_chk.sv
module drdy_flag_gen_chk #(
   parameter int unsigned W = 24
) (
   input logic         clk,
   input logic         rst_n,
   input logic         res_stb,
   input logic         upd_pending,
   input logic         rd_done,
   input logic         drdy_n,
   input logic [W-1:0] out_word,
   input logic [7:0]   stat_reg
);
   p_strobe_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_stb |=> drdy_n);

   p_word_moves_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_word != $past(out_word)) |-> $past(drdy_n));

   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !drdy_n) |=> drdy_n);

   p_hold_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pending |-> drdy_n);

   p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_reg[7] == drdy_n);
endmodule

bind drdy_flag_gen drdy_flag_gen_chk #(.W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .res_stb     (res_stb),
   .upd_pending (upd_pending),
   .rd_done     (rd_done),
   .drdy_n      (drdy_n),
   .out_word    (out_word),
   .stat_reg    (stat_reg)
);

// File: tb/drdy_flag_gen_tb.sv
module drdy_flag_gen_tb;
   localparam int unsigned W   = 24;
   localparam int unsigned PRE = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          res_stb = 1'b0;
   logic [W-1:0]  res_word = '0;
   logic          upd_pending = 1'b0;
   logic          rd_done = 1'b0;
   logic [6:0]    cfg_bits = '0;
   logic          drdy_n;
   logic [W-1:0]  out_word;
   logic [7:0]    stat_reg;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   drdy_flag_gen #(.W(W), .PRE_CYC(PRE)) u_dut (.*);

   // cycle model built from the requirements
   int           m_cnt = 0;
   logic [W-1:0] m_stage = '0;
   logic [W-1:0] m_out = '0;
   bit           m_fresh = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         m_cnt <= 0; m_stage <= '0; m_out <= '0; m_fresh <= 1'b0;
      end else begin
         if (res_stb) begin
            m_stage <= res_word;
            m_cnt   <= PRE;
         end else if (m_cnt != 0) begin
            m_cnt <= m_cnt - 1;
            if (m_cnt == 1) begin
               m_out   <= m_stage;
               m_fresh <= 1'b1;
            end
         end
         if (rd_done && m_cnt == 0) m_fresh <= 1'b0;
      end
   end

   function automatic bit exp_drdy();
      return !m_fresh || (m_cnt != 0) || upd_pending;
   endfunction

   function automatic logic [7:0] exp_stat();
      return {exp_drdy(), cfg_bits};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // compare at the falling edge, then the caller drives new inputs
   task automatic step(input string tag);
      @(negedge clk);
      chk(drdy_n == exp_drdy(), {tag, " drdy_n"}, 32'(drdy_n), 32'(exp_drdy()));
      chk(out_word == m_out, {tag, " out_word"}, 32'(out_word), 32'(m_out));
      chk(stat_reg == exp_stat(), "R8 stat_reg", 32'(stat_reg), 32'(exp_stat()));
   endtask

   task automatic idle_in();
      res_stb = 1'b0; rd_done = 1'b0; upd_pending = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int hi;
      void'($urandom(32'h5EED_0042));
      // R1: reset values
      repeat (3) step("R1");
      rst_n = 1'b1;
      step("R1");
      chk(drdy_n == 1'b1 && out_word == '0, "R1 post-reset", {out_word[30:0], drdy_n}, 32'h1);

      // R2/R3: strobe, count the high window
      res_word = 24'hA1B2C3; res_stb = 1'b1;
      step("R3"); idle_in();
      hi = 0;
      for (int i = 0; i < 20 && drdy_n; i++) begin hi++; step("R3"); end
      chk(hi == PRE, "R2 window length", 32'(hi), 32'(PRE));
      chk(out_word == 24'hA1B2C3, "R2 word loaded", 32'(out_word), 32'hA1B2C3);

      // R4: read clears
      rd_done = 1'b1; step("R4"); rd_done = 1'b0;
      step("R4");
      chk(drdy_n == 1'b1, "R4 read clears", 32'(drdy_n), 32'h1);

      // R5: read inside the window is ignored
      res_word = 24'h0F0F0F; res_stb = 1'b1; step("R5"); res_stb = 1'b0;
      step("R5"); rd_done = 1'b1; step("R5"); rd_done = 1'b0;
      repeat (PRE + 1) step("R5");
      chk(drdy_n == 1'b0 && out_word == 24'h0F0F0F, "R5 update survives", 32'(out_word), 32'h0F0F0F);

      // R6: restrike replaces staged word
      res_word = 24'h111111; res_stb = 1'b1; step("R6"); res_stb = 1'b0;
      step("R6");
      res_word = 24'h222222; res_stb = 1'b1; step("R6"); res_stb = 1'b0;
      repeat (PRE + 1) step("R6");
      chk(out_word == 24'h222222, "R6 newest word", 32'(out_word), 32'h222222);

      // R7: hold over an unread word
      upd_pending = 1'b1; cfg_bits = 7'h55;
      repeat (3) step("R7");
      chk(drdy_n == 1'b1, "R7 forced high", 32'(drdy_n), 32'h1);
      upd_pending = 1'b0; step("R7");
      chk(drdy_n == 1'b0, "R7 ready returns", 32'(drdy_n), 32'h0);

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         res_stb     = ($urandom_range(0, 9) == 0);
         res_word    = W'($urandom);
         rd_done     = ($urandom_range(0, 5) == 0);
         upd_pending = ($urandom_range(0, 11) == 0);
         cfg_bits    = 7'($urandom);
         step("R2");
      end
      idle_in();
      step("R2");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule